// File: doc/BRIEF.md
# Fan PWM Duty Generator

This block drives one cooling fan with a pulse-width-modulated signal. An 8-bit duty register is written and read over a minimal single-register bus. A free-running counter sets the period, and the output stays high for a number of clocks equal to the programmed code. Two codes are fixed regardless of the counter: the all-zero code gives a flat low output and the all-ones code gives a flat high output.

A smart-mode input hands control to an external controller. While it is set, that controller's duty word drives the waveform and a read of the register returns that word. Host writes are still stored, and they take effect again when smart mode is cleared. A change of duty, from either source, is applied only at a period boundary, so no pulse is ever cut short or stretched.

Top module: `fan_pwm_gen`

## Requirements
- R1: While rst_ni is low and right after it is released, the stored duty reads FFh, the period counter is at 0 and pwm_o is high.
- R2: The period counter advances by one on every clock and wraps from 255 to 0, so one period is exactly 256 clocks.
- R3: For an active code N from 01h to FEh, pwm_o is high at counts 0 to N-1 of every period and low at counts N to 255.
- R4: Active code 00h keeps pwm_o low on every clock, with no pulse at count 0.
- R5: Active code FFh keeps pwm_o high on every clock, including count 255.
- R6: The active code is taken on the clock edge that ends count 255 and is held for the whole next period. Writes and mode changes made during a period do not alter that period's waveform.
- R7: When smart_en_i is 1 at the period boundary, the next active code is auto_duty_i. When it is 0, the next active code is the stored host value.
- R8: reg_rdata_o equals auto_duty_i while smart_en_i is 1 and equals the stored host value while smart_en_i is 0. It follows both inputs combinationally.
- R9: Host writes made while smart_en_i is 1 update the stored value. That value drives pwm_o from the first period boundary after smart_en_i returns to 0.
- R10: A clock edge with reg_we_i high loads reg_wdata_i into the stored value, and the value is visible on reg_rdata_o in manual mode from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Write strobe for the duty register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, either the stored duty or the automatic duty |
| smart_en_i | input | 1 | Selects automatic duty control |
| auto_duty_i | input | 8 | Duty word from the external controller |
| pwm_o | output | 1 | Fan PWM output |

## Verification
The embedded assertions check on every cycle:
- the counter steps and wraps (R2);
- the active code holds steady away from the boundary (R6);
- the flat-low and flat-high codes (R4, R5);
- the loading of writes (R10).

Only the bench scenarios can show the rest, against an independent per-cycle model of counter, stored value and active code:
- the exact high-time per code (R3);
- that a write made mid-period changes nothing until the wrap (R6);
- the source selection at the boundary (R7);
- the combinational readback (R8);
- the reuse of a value written during smart mode (R9).

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  typedef enum logic {
    SRC_HOST = 1'b0,
    SRC_AUTO = 1'b1
  } duty_src_e;
endpackage

// File: rtl/fan_pwm_counter.sv
module fan_pwm_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == CNT_MAX);

  a_r2_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r2_cnt_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> (cnt_q == '0));
endmodule

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
  import fan_pwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  duty_src_e    src_i,
  input  logic [W-1:0] auto_duty_i,
  output logic [W-1:0] host_duty_o,
  output logic [W-1:0] rdata_o
);
  localparam logic [W-1:0] DUTY_RST = '1;

  logic [W-1:0] host_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   host_q <= DUTY_RST;
    else if (we_i) host_q <= wdata_i;
  end

  assign host_duty_o = host_q;
  // readback mirrors whichever source currently owns the fan
  assign rdata_o = (src_i == SRC_AUTO) ? auto_duty_i : host_q;

  a_r10_write_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (host_q == $past(wdata_i)));
  a_r9_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(host_q));
endmodule

// File: rtl/fan_pwm_out.sv
module fan_pwm_out #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         wrap_i,
  input  logic [W-1:0] next_duty_i,
  output logic         pwm_o
);
  localparam logic [W-1:0] DUTY_FULL = '1;
  localparam logic [W-1:0] DUTY_ZERO = '0;

  logic [W-1:0] act_q;
  logic         full;

  // active code only changes at the period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= DUTY_FULL;
    else if (wrap_i) act_q <= next_duty_i;
  end

  assign full  = (act_q == DUTY_FULL);
  assign pwm_o = full | (cnt_i < act_q);

  a_r6_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(act_q));
  a_r4_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == DUTY_ZERO) |-> !pwm_o);
  a_r5_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == DUTY_FULL) |-> pwm_o);
  a_r3_start_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_i == DUTY_ZERO) && (act_q != DUTY_ZERO)) |-> pwm_o);
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pwm_pkg::*;
#(
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [DUTY_W-1:0] reg_wdata_i,
  output logic [DUTY_W-1:0] reg_rdata_o,
  input  logic              smart_en_i,
  input  logic [DUTY_W-1:0] auto_duty_i,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] cnt;
  logic              wrap;
  logic [DUTY_W-1:0] host_duty;
  logic [DUTY_W-1:0] next_duty;
  duty_src_e         src;

  assign src       = smart_en_i ? SRC_AUTO : SRC_HOST;
  assign next_duty = (src == SRC_AUTO) ? auto_duty_i : host_duty;

  fan_pwm_counter #(.W(DUTY_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  fan_pwm_regs #(.W(DUTY_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .wdata_i     (reg_wdata_i),
    .src_i       (src),
    .auto_duty_i (auto_duty_i),
    .host_duty_o (host_duty),
    .rdata_o     (reg_rdata_o)
  );

  fan_pwm_out #(.W(DUTY_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_i       (cnt),
    .wrap_i      (wrap),
    .next_duty_i (next_duty),
    .pwm_o       (pwm_o)
  );
endmodule

// File: tb/fan_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module fan_pwm_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       smart = 1'b0;
  logic [7:0] auto_d = 8'h00;
  logic       pwm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model
  int m_cnt, m_stored, m_act;

  always #2 clk = ~clk;

  fan_pwm_gen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .smart_en_i  (smart),
    .auto_duty_i (auto_d),
    .pwm_o       (pwm)
  );

  function automatic bit exp_pwm(int cnt, int act);
    if (act == 255) return 1'b1;
    return (cnt < act);
  endfunction

  function automatic int exp_rd(bit sm, int au, int st);
    return sm ? au : st;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cnt %0d)", tag, what, act, exp, m_cnt);
    end
  endtask

  task automatic check_now(string tag);
    check(tag, "pwm_o", int'(pwm), int'(exp_pwm(m_cnt, m_act)));
    check(tag, "reg_rdata_o", int'(rdata), exp_rd(smart, int'(auto_d), m_stored));
  endtask

  // inputs driven at negedge, model advanced at posedge, outputs checked after
  task automatic step(string tag, bit w, int wd, bit sm, int au);
    we = w; wdata = 8'(wd); smart = sm; auto_d = 8'(au);
    #0.5;
    check_now(tag);
    @(posedge clk);
    if (m_cnt == 255) m_act = sm ? au : m_stored;
    if (w) m_stored = wd;
    m_cnt = (m_cnt + 1) % 256;
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n, bit sm, int au);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 0, sm, au);
  endtask

  task automatic to_count(string tag, int c, bit sm, int au);
    while (m_cnt != c) step(tag, 1'b0, 0, sm, au);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #0.5;
    check("R1", "pwm_o in reset", int'(pwm), 1);
    check("R1", "reg_rdata_o in reset", int'(rdata), 255);
    rst_n = 1'b1;
    m_cnt = 0; m_stored = 255; m_act = 255;

    // R1/R5: default FFh holds high across a full period
    idle("R5", 300, 1'b0, 0);

    // R10 + R6: write mid-period, readback next cycle, waveform unchanged till wrap
    to_count("R6", 100, 1'b0, 0);
    step("R10", 1'b1, 8'h10, 1'b0, 0);
    check("R10", "readback after write", int'(rdata), 8'h10);
    idle("R6", 400, 1'b0, 0);

    // R3: general codes including 01h and FEh
    step("R3", 1'b1, 8'h01, 1'b0, 0); idle("R3", 520, 1'b0, 0);
    step("R3", 1'b1, 8'hFE, 1'b0, 0); idle("R3", 520, 1'b0, 0);
    step("R3", 1'b1, 8'h80, 1'b0, 0); idle("R3", 300, 1'b0, 0);

    // R2: spacing of rising edges equals 256 clocks
    begin
      int gap;
      to_count("R2", 0, 1'b0, 0);
      gap = 0;
      step("R2", 1'b0, 0, 1'b0, 0);
      gap++;
      while (!(pwm == 1'b1 && m_cnt == 0)) begin
        step("R2", 1'b0, 0, 1'b0, 0);
        gap++;
      end
      check("R2", "period length", gap, 256);
    end

    // R4: zero code, including write landing exactly at count 255
    to_count("R4", 255, 1'b0, 0);
    step("R4", 1'b1, 8'h00, 1'b0, 0);
    idle("R4", 520, 1'b0, 0);

    // R7/R8: smart mode takes auto duty, readback follows auto input
    step("R7", 1'b0, 0, 1'b1, 8'h30);
    idle("R7", 400, 1'b1, 8'h30);
    step("R8", 1'b0, 0, 1'b1, 8'hA5);
    check("R8", "smart readback", int'(rdata), 8'hA5);
    idle("R8", 300, 1'b1, 8'hC0);

    // R9: write in smart mode, reused after smart cleared
    step("R9", 1'b1, 8'h60, 1'b1, 8'hC0);
    check("R9", "smart still reads auto", int'(rdata), 8'hC0);
    idle("R9", 300, 1'b1, 8'hC0);
    step("R9", 1'b0, 0, 1'b0, 8'hC0);
    check("R9", "manual reads stored", int'(rdata), 8'h60);
    idle("R9", 520, 1'b0, 8'hC0);

    // random mix
    begin
      bit sm = 1'b0;
      int au = 8'h40;
      for (int i = 0; i < 6000; i++) begin
        bit w = ($urandom_range(0, 39) == 0);
        int wd = $urandom_range(0, 255);
        if ($urandom_range(0, 199) == 0) sm = ~sm;
        if ($urandom_range(0, 99) == 0) au = $urandom_range(0, 255);
        if ($urandom_range(0, 9) == 0) wd = ($urandom_range(0, 1) != 0) ? 255 : 0;
        step("R3", w, wd, sm, au);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule